// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by an integer modulus picked by an 11-bit divide word. A dual-modulus prescaler counts input clocks by either 8 or 9. A main counter counts prescaler cycles up to M. A swallow counter keeps the prescaler at 9 for the first A prescaler cycles of each output period, so that each period adds A extra input clocks. One output period therefore lasts M×8+A input clocks. The block is the feedback divider of a frequency synthesiser loop, and it runs directly on the fast clock.

The block gives a one-clock strobe at the end of every period and a registered divided clock that changes level with each strobe. The divide word is a plain control input, not a data stream, so the block has no valid/ready handshake and never applies back-pressure. The word is taken at reset and at each period boundary. While the captured word is unusable (M of zero, or A above M), a flag is raised, both outputs stay low, and the word input is taken on every clock until a usable value arrives.

Top module: `swallow_divider`

## Requirements
- R1: The divide word holds M in bits [10:3] and A in bits [2:0]. With a legal word, div_pulse is high once every M×8+A clocks.
- R2: The prescaler counts 9 input clocks for each of the first A prescaler cycles of a period and 8 for the others. With A=0 the period is M×8, and with A=M it is M×9.
- R3: Within a period, the number of prescaler cycles counted at 9 never exceeds A.
- R4: Reset (synchronous, active high) clears both outputs and captures div_word. With a legal word, the first div_pulse is high in the cycle after the M×8+A-th rising edge that sees reset low.
- R5: div_pulse is exactly one clock wide.
- R6: A change on div_word inside a period does not alter that period. The value present in a period's final clock governs the next period.
- R7: bad_setting is high whenever the captured word has M=0 or A>M. While it is high, div_pulse and div_clk are low. This includes the strobe of a period whose boundary captures an illegal word.
- R8: While bad_setting is high, div_word is captured on every clock. After a legal word is captured at edge E, the flag drops and the first div_pulse follows edge E+M×8+A.
- R9: div_clk is low after reset and inverts together with each div_pulse, giving a period of 2×(M×8+A) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also captures div_word |
| div_word | input | 11 | Divide word: M in [10:3], A in [2:0] |
| div_pulse | output | 1 | One-clock strobe at the end of each period |
| div_clk | output | 1 | Divided clock, inverts on each strobe |
| bad_setting | output | 1 | Captured word is unusable (M=0 or A>M) |

## Verification
Two functions can fall in the same clock. The first pair is the period-end strobe and the capture of a new word. The bench counts down to the final clock of a 56-clock period and changes the word exactly there. It expects the old period to end on time and the very next spacing to follow the new word. The second pair is the period end and a switch to an illegal word. The bench expects that strobe to be suppressed, with both outputs quiet from then on. A separate case changes the word in the middle of a period; the bench judges it by measured spacings that must still equal the old modulus.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned SWD_M_W = 8;
  localparam int unsigned SWD_A_W = 3;

  typedef enum logic {
    PS_BASE    = 1'b0,
    PS_SWALLOW = 1'b1
  } ps_mode_e;
endpackage

// File: rtl/swd_word_latch.sv
module swd_word_latch #(
  parameter int unsigned M_W = swd_pkg::SWD_M_W,
  parameter int unsigned A_W = swd_pkg::SWD_A_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [M_W+A_W-1:0] word,
  output logic [M_W-1:0]     m_act,
  output logic [A_W-1:0]     a_act,
  output logic               bad
);
  // capture at reset and whenever the sequencer allows it
  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      m_act <= word[M_W+A_W-1:A_W];
      a_act <= word[A_W-1:0];
    end
  end

  always_comb begin
    bad = (m_act == '0) || (M_W'(a_act) > m_act);
  end
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int unsigned A_W = swd_pkg::SWD_A_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  swd_pkg::ps_mode_e  mode,
  output logic               tick
);
  import swd_pkg::*;

  localparam int unsigned N  = 1 << A_W;
  localparam int unsigned CW = A_W + 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] last;

  always_comb begin
    last = (mode == PS_SWALLOW) ? CW'(N) : CW'(N - 1);
    tick = run && (pcnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + CW'(1);
    end
  end

  // R2
  pscale_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt <= CW'(N));

  // R2
  swallow_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (pcnt == CW'(N)) |-> (mode == PS_SWALLOW));
endmodule

// File: rtl/swd_mod_counter.sv
module swd_mod_counter #(
  parameter int unsigned M_W = swd_pkg::SWD_M_W,
  parameter int unsigned A_W = swd_pkg::SWD_A_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic [M_W-1:0]     m_act,
  input  logic [A_W-1:0]     a_act,
  output swd_pkg::ps_mode_e  mode,
  output logic               cycle_end
);
  import swd_pkg::*;

  logic [M_W-1:0] mcnt;
  logic [A_W-1:0] acnt;
  logic           m_last;

  always_comb begin
    mode      = (acnt < a_act) ? PS_SWALLOW : PS_BASE;
    m_last    = (mcnt == (m_act - M_W'(1)));
    cycle_end = tick && m_last;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      mcnt <= '0;
      acnt <= '0;
    end else if (tick) begin
      if (m_last) begin
        mcnt <= '0;
        acnt <= '0;
      end else begin
        mcnt <= mcnt + M_W'(1);
        acnt <= acnt + A_W'(mode == PS_SWALLOW);
      end
    end
  end

  // R3
  swallow_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (acnt <= a_act));

  // R1
  main_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (mcnt < m_act));
endmodule

// File: rtl/swd_out_stage.sv
module swd_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic cycle_end,
  input  logic bad,
  output logic div_pulse,
  output logic div_clk
);
  logic pulse_q;
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= cycle_end;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bad) begin
      tog_q <= 1'b0;
    end else if (cycle_end) begin
      tog_q <= ~tog_q;
    end
  end

  always_comb begin
    div_pulse = pulse_q & ~bad;
    div_clk   = tog_q & ~bad;
  end

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R9
  toggle_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!bad && !$past(bad) && (div_clk != $past(div_clk))) |-> div_pulse);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned M_W = swd_pkg::SWD_M_W,
  parameter int unsigned A_W = swd_pkg::SWD_A_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [M_W+A_W-1:0] div_word,
  output logic               div_pulse,
  output logic               div_clk,
  output logic               bad_setting
);
  import swd_pkg::*;

  logic [M_W-1:0] m_act;
  logic [A_W-1:0] a_act;
  logic           bad;
  logic           run;
  logic           tick;
  logic           cycle_end;
  logic           load_en;
  ps_mode_e       mode;

  always_comb begin
    run         = ~bad;
    load_en     = cycle_end | bad;
    bad_setting = bad;
  end

  swd_word_latch #(.M_W(M_W), .A_W(A_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .word    (div_word),
    .m_act   (m_act),
    .a_act   (a_act),
    .bad     (bad)
  );

  swd_prescaler #(.A_W(A_W)) u_prescaler (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .mode (mode),
    .tick (tick)
  );

  swd_mod_counter #(.M_W(M_W), .A_W(A_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (tick),
    .m_act     (m_act),
    .a_act     (a_act),
    .mode      (mode),
    .cycle_end (cycle_end)
  );

  swd_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .cycle_end (cycle_end),
    .bad       (bad),
    .div_pulse (div_pulse),
    .div_clk   (div_clk)
  );

  // R6
  mid_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cycle_end) && !$past(bad)) |-> ($stable(m_act) && $stable(a_act)));

  // R7
  invalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bad |-> !cycle_end);
endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] div_word = {8'd7, 3'd0};
  logic        div_pulse;
  logic        div_clk;
  logic        bad_setting;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk         (clk),
    .rst         (rst),
    .div_word    (div_word),
    .div_pulse   (div_pulse),
    .div_clk     (div_clk),
    .bad_setting (bad_setting)
  );

  // {M, A, expected spacing}
  localparam logic [22:0] VEC [12] = '{
    {8'd7,   3'd0, 12'd56},
    {8'd7,   3'd1, 12'd57},
    {8'd1,   3'd0, 12'd8},
    {8'd1,   3'd1, 12'd9},
    {8'd7,   3'd7, 12'd63},
    {8'd12,  3'd4, 12'd100},
    {8'd255, 3'd7, 12'd2047},
    {8'd125, 3'd0, 12'd1000},
    {8'd2,   3'd2, 12'd18},
    {8'd154, 3'd2, 12'd1234},
    {8'd64,  3'd1, 12'd513},
    {8'd255, 3'd0, 12'd2040}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [10:0] w);
    @(negedge clk);
    div_word = w;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 5000);
  endtask

  task automatic count_quiet(input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (div_pulse || div_clk) hits++;
    end
  endtask

  initial begin
    #950000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int hits;
    // R4 reset state
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R4 reset pulse", div_pulse, 0);
    check(div_clk == 1'b0, "R9 reset div_clk", div_clk, 0);
    check(bad_setting == 1'b0, "R7 reset flag legal word", bad_setting, 0);

    // table walk: R1, R4, R5, R9
    for (int i = 0; i < 12; i++) begin
      int exp;
      exp = int'(VEC[i][11:0]);
      do_reset(VEC[i][22:12]);
      wait_pulse(n);
      check(n == exp, "R4 first pulse", n, exp);
      check(div_clk == 1'b1, "R9 div_clk after first", div_clk, 1);
      wait_pulse(n);
      check(n == exp, "R1 spacing", n, exp);
      check(div_clk == 1'b0, "R9 div_clk after second", div_clk, 0);
      @(negedge clk);
      check(div_pulse == 1'b0, "R5 width", div_pulse, 0);
    end

    // R2 sweep of small moduli, including A=0 and A=M
    for (int m = 1; m <= 7; m++) begin
      for (int a = 0; a <= m; a++) begin
        do_reset({8'(m), 3'(a)});
        wait_pulse(n);
        check(n == m * 8 + a, "R2 first", n, m * 8 + a);
        wait_pulse(n);
        check(n == m * 8 + a, "R2 spacing", n, m * 8 + a);
      end
    end

    // R6 mid-period change
    do_reset({8'd12, 3'd4});
    wait_pulse(n);
    repeat (30) @(negedge clk);
    div_word = {8'd7, 3'd0};
    wait_pulse(n);
    check(n == 70, "R6 old period kept", n, 70);
    wait_pulse(n);
    check(n == 56, "R6 new period", n, 56);
    // R6 change in the final clock of a period
    repeat (55) @(negedge clk);
    div_word = {8'd1, 3'd1};
    wait_pulse(n);
    check(n == 1, "R6 boundary strobe", n, 1);
    wait_pulse(n);
    check(n == 9, "R6 boundary capture", n, 9);

    // R7 illegal words
    do_reset({8'd0, 3'd3});
    check(bad_setting == 1'b1, "R7 M zero", bad_setting, 1);
    count_quiet(300, hits);
    check(hits == 0, "R7 quiet M zero", hits, 0);
    do_reset({8'd0, 3'd0});
    check(bad_setting == 1'b1, "R7 all zero", bad_setting, 1);
    do_reset({8'd2, 3'd5});
    check(bad_setting == 1'b1, "R7 A above M", bad_setting, 1);
    count_quiet(100, hits);
    check(hits == 0, "R7 quiet A above M", hits, 0);

    // R8 recovery without reset
    div_word = {8'd3, 3'd2};
    @(negedge clk);
    check(bad_setting == 1'b0, "R8 flag drops", bad_setting, 0);
    wait_pulse(n);
    check(n + 1 == 27, "R8 first pulse", n + 1, 27);
    wait_pulse(n);
    check(n == 26, "R8 spacing", n, 26);

    // R7 switch to illegal at a boundary
    repeat (5) @(negedge clk);
    div_word = {8'd1, 3'd4};
    count_quiet(100, hits);
    check(hits == 0, "R7 strobe suppressed", hits, 0);
    check(bad_setting == 1'b1, "R7 flag after boundary", bad_setting, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule